// File: doc/BRIEF.md
# Half-Bridge Dead-Time Interlock Controller

This block sits between a PWM modulator and the two gate drivers of a synchronous buck half-bridge. It turns a single PWM command into a high-side enable and a low-side enable, and it never lets the two switches conduct together. When the PWM command falls, the low side is not switched on at a fixed time. It waits until a comparator reports that the switch node has actually dropped low. When the PWM command rises, the high side is switched on only after the low side has been off for a counted dead time. That dead time is a base count plus an optional extra count, both set by parameters.

The block also has three protection paths. An over-voltage flag that persists beyond a glitch-filter window forces the low side on and the high side off, so the output capacitors can discharge. An over-temperature flag and a deasserted driver enable both turn every gate off. A mode input selects synchronous operation or diode-only asynchronous operation, in which the low side is never driven. A mirror output repeats the low-side enable in synchronous mode only.

Top module: `hb_interlock_ctrl`

## Requirements
- R1: The high-side enable and the low-side enable are never high in the same cycle.
- R2: After the PWM command falls, the low-side enable stays low until the phase-low flag is sampled high in synchronous mode. It then goes high at that same clock edge.
- R3: The high-side enable rises exactly BASE_CYC+EXTRA_CYC clock edges after the first edge at which PWM is sampled high with the low side already switched off. The low-side enable is low throughout that window.
- R4: An edge that samples PWM low leaves the high-side enable low.
- R5: An edge that samples the mode input low (asynchronous mode) leaves the low-side enable low, whatever the PWM, phase-low or over-voltage inputs are doing.
- R6: The mirror output equals the low-side enable while the mode input is high. It is low at once whenever the mode input is low.
- R7: An edge that samples the driver enable low drives all three outputs low. After the enable returns, sequencing restarts with the dead-time count.
- R8: An edge that samples the over-temperature flag high drives both gate enables low. This takes priority over an active over-voltage override.
- R9: When the over-voltage flag is sampled high on more than OVP_FILT_CYC consecutive edges, the next edge turns the high side off and sets the low side to the mode input, regardless of PWM. The override holds while the flag stays high.
- R10: An over-voltage pulse sampled high on OVP_FILT_CYC or fewer consecutive edges has no effect on any output.
- R11: The first edge that samples the over-voltage flag low ends the override with both gates off. Normal sequencing then resumes from that all-off state, including the full dead-time count.
- R12: While reset is asserted, and for two clock edges after it is released, all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset, released through a two-stage synchronizer |
| pwm_i | input | 1 | PWM command: 1 requests the high side on |
| phase_low_i | input | 1 | Switch-node-low comparator flag |
| sync_mode_i | input | 1 | 1 selects synchronous mode, 0 selects asynchronous mode |
| drv_en_i | input | 1 | Driver enable, active high |
| ovp_flag_i | input | 1 | Over-voltage comparator flag |
| otemp_i | input | 1 | Over-temperature flag |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |
| ls_mirror_o | output | 1 | Copy of the low-side enable, gated by the mode input |

## Verification
The bench builds the block with BASE_CYC=2, EXTRA_CYC=3 and OVP_FILT_CYC=4. With these values the dead-time count is five edges, which is short enough to check the high-side rise on the exact edge, one edge early and one edge late. The filter window is short enough to drive pulses exactly at the window length and one edge beyond it, so both sides of the over-voltage boundary are exercised. The small counts also allow the override, the over-temperature pre-emption and the recovery through the full dead time to be run back to back in a short run.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_LS_WAIT,
    ST_LS_ON,
    ST_HS_DLY,
    ST_HS_ON,
    ST_OVP
  } hb_state_e;
endpackage

// File: rtl/hb_ovp_filter.sv
`timescale 1ns/1ps
module hb_ovp_filter #(
  parameter int FILT_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic flag_i,
  output logic active_o
);
  localparam int CW = $clog2(FILT_CYC + 1);
  localparam logic [CW-1:0] FILT_V = CW'(FILT_CYC);

  logic [CW-1:0] run_q, run_d;
  logic          run_en;
  logic          lat_q, lat_d;

  // Consecutive-high run length, saturating at the window length.
  always_comb begin
    run_en = 1'b1;
    run_d  = run_q;
    if (!flag_i) begin
      run_d = '0;
    end else if (run_q == FILT_V) begin
      run_en = 1'b0;
    end else begin
      run_d = run_q + 1'b1;
    end
  end

  // The latch sets once the run has outlasted the window, and clears as soon as the flag is low.
  always_comb begin
    lat_d = flag_i & (lat_q | (run_q == FILT_V));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= '0;
      lat_q <= 1'b0;
    end else begin
      if (run_en) run_q <= run_d;
      lat_q <= lat_d;
    end
  end

  assign active_o = lat_q & flag_i;
endmodule

// File: rtl/hb_deadtime_seq.sv
`timescale 1ns/1ps
module hb_deadtime_seq
  import hb_pkg::*;
#(
  parameter int DLY_CYC = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  input  logic phase_low_i,
  input  logic sync_i,
  input  logic run_ok_i,
  input  logic ovp_i,
  output logic hs_o,
  output logic ls_o
);
  localparam int DW = $clog2(DLY_CYC + 1);
  localparam logic [DW-1:0] LAST_V = DW'(DLY_CYC - 1);

  hb_state_e     st_q, st_d;
  logic [DW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          hs_q, hs_d, ls_q, ls_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = '0;
    cnt_en = 1'b1;
    if (!run_ok_i) begin
      st_d = ST_OFF;
    end else if (ovp_i) begin
      st_d = ST_OVP;
    end else begin
      unique case (st_q)
        ST_OVP: st_d = ST_OFF;
        ST_OFF: begin
          if (pwm_i)       st_d = ST_HS_DLY;
          else if (sync_i) st_d = ST_LS_WAIT;
        end
        ST_LS_WAIT: begin
          if (pwm_i)            st_d = ST_HS_DLY;
          else if (!sync_i)     st_d = ST_OFF;
          else if (phase_low_i) st_d = ST_LS_ON;
        end
        ST_LS_ON: begin
          if (pwm_i)        st_d = ST_HS_DLY;
          else if (!sync_i) st_d = ST_LS_WAIT;
        end
        ST_HS_DLY: begin
          if (!pwm_i) begin
            st_d = sync_i ? ST_LS_WAIT : ST_OFF;
          end else if (cnt_q == LAST_V) begin
            st_d = ST_HS_ON;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        ST_HS_ON: begin
          if (!pwm_i) st_d = sync_i ? ST_LS_WAIT : ST_OFF;
        end
        default: st_d = ST_OFF;
      endcase
    end
    if (cnt_d == cnt_q) cnt_en = 1'b0;
  end

  always_comb begin
    hs_d = (st_d == ST_HS_ON);
    ls_d = sync_i & ((st_d == ST_LS_ON) | (st_d == ST_OVP));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_OFF;
      cnt_q <= '0;
      hs_q  <= 1'b0;
      ls_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
      hs_q <= hs_d;
      ls_q <= ls_d;
    end
  end

  assign hs_o = hs_q;
  assign ls_o = ls_q;
endmodule

// File: rtl/hb_interlock_ctrl.sv
`timescale 1ns/1ps
module hb_interlock_ctrl #(
  parameter int BASE_CYC     = 3,
  parameter int EXTRA_CYC    = 2,
  parameter int OVP_FILT_CYC = 12
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_i,
  input  logic phase_low_i,
  input  logic sync_mode_i,
  input  logic drv_en_i,
  input  logic ovp_flag_i,
  input  logic otemp_i,
  output logic hs_gate_o,
  output logic ls_gate_o,
  output logic ls_mirror_o
);
  localparam int HS_DLY = BASE_CYC + EXTRA_CYC;

  logic rst_meta_q, rst_sync_n;
  logic ovp_act;
  logic run_ok;
  logic ls_int;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  assign run_ok = drv_en_i & ~otemp_i;

  hb_ovp_filter #(.FILT_CYC(OVP_FILT_CYC)) ovp_filt_i (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .flag_i   (ovp_flag_i),
    .active_o (ovp_act)
  );

  hb_deadtime_seq #(.DLY_CYC(HS_DLY)) seq_i (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .pwm_i       (pwm_i),
    .phase_low_i (phase_low_i),
    .sync_i      (sync_mode_i),
    .run_ok_i    (run_ok),
    .ovp_i       (ovp_act),
    .hs_o        (hs_gate_o),
    .ls_o        (ls_int)
  );

  assign ls_gate_o   = ls_int;
  assign ls_mirror_o = ls_int & sync_mode_i;
endmodule

// File: rtl/hb_interlock_chk.sv
`timescale 1ns/1ps
module hb_interlock_chk #(
  parameter int DLY  = 5,
  parameter int FILT = 12
) (
  input logic clk,
  input logic rst_n,
  input logic pwm,
  input logic phase_low,
  input logic sync_mode,
  input logic drv_en,
  input logic ovp,
  input logic otemp,
  input logic hs,
  input logic ls,
  input logic mirror
);
  localparam int LW = $clog2(DLY + 1);
  localparam int RW = $clog2(FILT + 2);
  localparam logic [LW-1:0] DLY_V  = LW'(DLY);
  localparam logic [RW-1:0] FILT_V = RW'(FILT);

  logic [LW-1:0] lo_cnt;
  logic [RW-1:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      run_q  <= '0;
    end else begin
      if (ls)                   lo_cnt <= '0;
      else if (lo_cnt != DLY_V) lo_cnt <= lo_cnt + 1'b1;
      if (!ovp)                        run_q <= '0;
      else if (run_q <= FILT_V)        run_q <= run_q + 1'b1;
    end
  end

  assert_no_overlap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(hs && ls));

  assert_ls_needs_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ls) |-> ($past(phase_low) || $past(ovp)));

  assert_hs_deadtime_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hs) |-> (lo_cnt >= DLY_V));

  assert_pwm_low_hs_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm |=> !hs);

  assert_async_ls_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |=> !ls);

  assert_mirror_copy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_mode |-> (mirror == ls));

  assert_mirror_async_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_mode |-> !mirror);

  assert_disable_all_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !drv_en |=> (!hs && !ls && !mirror));

  assert_otemp_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    otemp |=> (!hs && !ls));

  assert_ovp_force_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovp && (run_q > FILT_V) && drv_en && !otemp) |=> (!hs && (ls == $past(sync_mode))));
endmodule

bind hb_interlock_ctrl hb_interlock_chk #(
  .DLY  (BASE_CYC + EXTRA_CYC),
  .FILT (OVP_FILT_CYC)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .pwm       (pwm_i),
  .phase_low (phase_low_i),
  .sync_mode (sync_mode_i),
  .drv_en    (drv_en_i),
  .ovp       (ovp_flag_i),
  .otemp     (otemp_i),
  .hs        (hs_gate_o),
  .ls        (ls_gate_o),
  .mirror    (ls_mirror_o)
);

// File: tb/hb_interlock_ctrl_tb_top.sv
`timescale 1ns/1ps
module hb_interlock_ctrl_tb_top;
  localparam int BASE = 2;
  localparam int EXTRA = 3;
  localparam int FILT = 4;
  localparam int DLY = BASE + EXTRA;
  localparam int WD_CYC = 200000;

  logic clk = 1'b0;
  logic rst_n, pwm, phase_low, sync_mode, drv_en, ovp, otemp;
  logic hs, ls, mirror;
  int n_run = 0;
  int n_fail = 0;
  int overlap = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  hb_interlock_ctrl #(
    .BASE_CYC(BASE), .EXTRA_CYC(EXTRA), .OVP_FILT_CYC(FILT)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_i(pwm), .phase_low_i(phase_low),
    .sync_mode_i(sync_mode), .drv_en_i(drv_en), .ovp_flag_i(ovp),
    .otemp_i(otemp), .hs_gate_o(hs), .ls_gate_o(ls), .ls_mirror_o(mirror)
  );

  always @(negedge clk) if (rst_n && hs && ls) overlap++;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Outputs packed as {hs, ls, mirror}
  task automatic check(input string req, input logic [2:0] exp);
    n_run++;
    if ({hs, ls, mirror} !== exp) begin
      n_fail++;
      $display("FAIL %s: {hs,ls,mirror} actual=%b expected=%b at %0t", req, {hs, ls, mirror}, exp, $time);
    end
  endtask

  task automatic hs_on_from_idle();
    pwm = 1'b1;
    tick(DLY);
    check("R3 one edge before dead time ends", 3'b000);
    tick(1);
    check("R3 high side after dead time", 3'b100);
  endtask

  task automatic t_reset_R12();
    rst_n = 1'b0; pwm = 1'b1; phase_low = 1'b1;
    tick(2);
    check("R12 in reset", 3'b000);
    rst_n = 1'b1;
    tick(1);
    check("R12 first edge after release", 3'b000);
    tick(1);
    check("R12 second edge after release", 3'b000);
    pwm = 1'b0; phase_low = 1'b0;
    tick(3);
  endtask

  task automatic t_bottom_R2_R4();
    hs_on_from_idle();
    pwm = 1'b0;
    tick(1);
    check("R4 high side off after pwm low", 3'b000);
    tick(3);
    check("R2 low side waits for phase low", 3'b000);
    phase_low = 1'b1;
    tick(1);
    check("R2 low side on after phase low, R6 mirror", 3'b011);
  endtask

  task automatic t_top_R3();
    pwm = 1'b1;
    tick(1);
    check("R3 low side off first edge", 3'b000);
    for (int k = 2; k <= DLY; k++) begin
      tick(1);
      check("R3 still in dead time", 3'b000);
    end
    tick(1);
    check("R3 high side on after dead time", 3'b100);
    phase_low = 1'b0;
    pwm = 1'b0;
    tick(1);
    phase_low = 1'b1;
    tick(1);
    check("R2 low side on again", 3'b011);
  endtask

  task automatic t_async_R5_R6();
    sync_mode = 1'b0;
    #1;
    check("R6 mirror drops with mode input", 3'b010);
    tick(1);
    check("R5 low side off in async mode", 3'b000);
    phase_low = 1'b0;
    hs_on_from_idle();
    pwm = 1'b0; phase_low = 1'b1;
    tick(3);
    check("R5 no low side after pwm falls in async", 3'b000);
    sync_mode = 1'b1;
    tick(1);
    check("R5 mode return edge", 3'b000);
    tick(1);
    check("R6 low side and mirror in sync mode", 3'b011);
    phase_low = 1'b0;
  endtask

  task automatic t_disable_R7();
    hs_on_from_idle();
    drv_en = 1'b0;
    tick(1);
    check("R7 disable turns all off", 3'b000);
    tick(3);
    check("R7 stays off while disabled", 3'b000);
    drv_en = 1'b1;
    tick(DLY);
    check("R7 dead time after re-enable", 3'b000);
    tick(1);
    check("R7 high side after re-enable", 3'b100);
  endtask

  task automatic t_ovp_short_R10();
    for (int p = 0; p < 2; p++) begin
      ovp = 1'b1;
      for (int k = 0; k < FILT; k++) begin
        tick(1);
        check("R10 short pulse ignored", 3'b100);
      end
      ovp = 1'b0;
      for (int k = 0; k < 3; k++) begin
        tick(1);
        check("R10 no effect after short pulse", 3'b100);
      end
    end
  endtask

  task automatic ovp_engage();
    ovp = 1'b1;
    tick(FILT + 1);
    check("R9 not yet forced", 3'b100);
    tick(1);
    check("R9 override forces low side", 3'b011);
  endtask

  task automatic t_ovp_long_R9_R11();
    ovp_engage();
    tick(3);
    check("R9 override holds against pwm", 3'b011);
    ovp = 1'b0;
    tick(1);
    check("R11 override ends all off", 3'b000);
    tick(DLY);
    check("R11 dead time before high side", 3'b000);
    tick(1);
    check("R11 high side resumes", 3'b100);
  endtask

  task automatic t_otemp_R8();
    ovp_engage();
    otemp = 1'b1;
    tick(1);
    check("R8 over-temp beats override", 3'b000);
    tick(2);
    check("R8 stays off", 3'b000);
    otemp = 1'b0; ovp = 1'b0;
    tick(DLY + 1);
    check("R8 recovery with dead time", 3'b100);
    otemp = 1'b1;
    tick(1);
    check("R8 over-temp turns high side off", 3'b000);
    otemp = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; pwm = 1'b0; phase_low = 1'b0; sync_mode = 1'b1;
    drv_en = 1'b1; ovp = 1'b0; otemp = 1'b0;
    tick(1);
    t_reset_R12();
    t_bottom_R2_R4();
    t_top_R3();
    t_async_R5_R6();
    t_disable_R7();
    t_ovp_short_R10();
    t_ovp_long_R9_R11();
    t_otemp_R8();
    tick(2);
    n_run++;
    if (overlap != 0) begin
      n_fail++;
      $display("FAIL R1: overlap cycles actual=%0d expected=0", overlap);
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (WD_CYC) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: finished actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule